// File: doc/BRIEF.md
# Oversampling Digital Clock and Data Recovery

The block recovers a serial bit stream from a receiver that samples the line with eight equally spaced clock phases. Once per bit period it takes a vector holding one sample from each phase slice. It looks for level changes between neighbouring phase samples, and it treats the last sample of the previous period as the neighbour of the first. Each change counts as a vote for an edge position.

A voting decimator gathers these votes over a fixed window of bit periods. At the end of the window it names the most frequent edge position as the edge estimate. The sampling phase then moves toward the point half a bit period away from that edge, which is the middle of the eye. The phase moves by at most one step per window, so no oscillator is tuned: the selector only picks which of the existing phase samples becomes the recovered bit. The block raises a lock flag once the chosen phase has stayed still for several windows in a row.

The line is expected to carry a DC-balanced code with bounded run length, so that edges arrive often enough to track.

Top module: `dcdr_core`

## Requirements
- R1: Bit k of `samp_i` is the sample of phase k, and bit 0 is the earliest. Edge position 0 is a level change between bit NPH-1 of the previous period and bit 0. Edge position k (k ≥ 1) is a change between bits k-1 and k. Every change adds one vote to its position. The previous-period sample is 0 after reset.
- R2: A voting window spans WIN_LEN bit periods (default 16), and the first window starts with the first period after reset. At the window's last period, that period's votes are included and the winner is chosen as follows. If the current edge estimate has as many votes as the maximum, the estimate is kept. Otherwise the winner is the lowest position holding the maximum. All vote counters then restart from zero.
- R3: The target sampling phase is (edge estimate + NPH/2) mod NPH.
- R4: The selected phase changes only at the end of a window. It changes by at most one step, taking the shorter way round toward the target. When the target is exactly opposite the current phase, the step is +1. Steps wrap modulo NPH.
- R5: A window with fewer than MIN_VOTES total votes (default 2) leaves the edge estimate, the phase and the lock flag unchanged.
- R6: Lock is raised at the end of the LOCK_WINS-th consecutive counted window (default 4) in which the phase did not move. A one-step move restarts that count but does not clear lock.
- R7: Lock is cleared when a window's winner is 2 or more circular steps away from the previous edge estimate.
- R8: `data_o` is `samp_i[phase_o]` of a period, registered, and it appears one clock after that period. `valid_o` is high from the first clock after reset is released.
- R9: Reset sets the phase to NPH/2 and the edge estimate to 0, clears the vote and window counters, and drives lock, `valid_o` and `data_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one cycle per bit period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samp_i | input | NPH | Phase-slice samples of the current bit period |
| data_o | output | 1 | Recovered bit |
| valid_o | output | 1 | Recovered bit is meaningful |
| phase_o | output | $clog2(NPH) | Selected sampling phase |
| lock_o | output | 1 | Phase has been stable for LOCK_WINS windows |

## Verification
The bench builds the core with its default values: eight phases, sixteen-period windows, a two-vote floor and a four-window lock count. These values keep every window short enough to walk the phase around the whole ring, wrapping past 7 to 0 and then stepping downward, within a few hundred cycles. The windows are fed with complete patterns of one edge position, so each window's winner is known by hand. Split windows test the tie rule, and windows with zero or one vote test the quiet rule.

// File: rtl/dcdr_pkg.sv
package dcdr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/dcdr_edge_finder.sv
module dcdr_edge_finder #(
  parameter int NPH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] samp_i,
  output logic [NPH-1:0] edges_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= samp_i[NPH-1];
  end

  assign edges_o[0] = last_q ^ samp_i[0];

  for (genvar k = 1; k < NPH; k++) begin : g_pair
    assign edges_o[k] = samp_i[k-1] ^ samp_i[k];
  end
endmodule

// File: rtl/dcdr_vote_window.sv
module dcdr_vote_window #(
  parameter int NPH     = 8,
  parameter int WIN_LEN = 16,
  localparam int PW = $clog2(NPH),
  localparam int CW = $clog2(WIN_LEN + 1),
  localparam int WW = $clog2(WIN_LEN),
  localparam int VW = $clog2(NPH * WIN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NPH-1:0] edges_i,
  input  logic [PW-1:0] cur_est_i,
  output logic          win_end_o,
  output logic [PW-1:0] winner_o,
  output logic [VW-1:0] votes_o
);
  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q [NPH];
  logic [CW-1:0] sum   [NPH];

  assign win_end_o = (win_q == WW'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '0;
    else if (win_end_o) win_q <= '0;
    else                win_q <= win_q + 1'b1;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_cnt
    assign sum[k] = cnt_q[k] + CW'(edges_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q[k] <= '0;
      else if (win_end_o) cnt_q[k] <= '0;
      else                cnt_q[k] <= sum[k];
    end

    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[k] <= CW'(WIN_LEN - 1));
  end

  // strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    logic [CW-1:0] best;
    logic [PW-1:0] idx;
    best = '0;
    idx  = '0;
    votes_o = '0;
    for (int k = 0; k < NPH; k++) begin
      votes_o = votes_o + VW'(sum[k]);
      if (sum[k] > best) begin
        best = sum[k];
        idx  = PW'(k);
      end
    end
    if (sum[cur_est_i] == best) idx = cur_est_i;
    winner_o = idx;
  end

  p_window_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> !win_end_o);
endmodule

// File: rtl/dcdr_phase_ctrl.sv
module dcdr_phase_ctrl
  import dcdr_pkg::*;
#(
  parameter int NPH       = 8,
  parameter int WIN_LEN   = 16,
  parameter int MIN_VOTES = 2,
  parameter int LOCK_WINS = 4,
  localparam int PW   = $clog2(NPH),
  localparam int VW   = $clog2(NPH * WIN_LEN + 1),
  localparam int SW   = $clog2(LOCK_WINS + 1),
  localparam int HALF = NPH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_end_i,
  input  logic [PW-1:0] winner_i,
  input  logic [VW-1:0] votes_i,
  output logic [PW-1:0] est_o,
  output logic [PW-1:0] phase_o,
  output logic          lock_o
);
  logic [PW-1:0] est_q, phase_q, tgt, diff, est_d;
  logic [SW-1:0] stab_q;
  logic          lock_q, upd, far;
  step_e         step;

  assign upd = win_end_i && (votes_i >= VW'(MIN_VOTES));

  always_comb begin
    tgt  = winner_i + PW'(HALF);
    diff = tgt - phase_q;
    if (diff == '0)               step = STEP_HOLD;
    else if (diff <= PW'(HALF))   step = STEP_UP;
    else                          step = STEP_DN;
    est_d = winner_i - est_q;
    far   = !(est_d == '0 || est_d == PW'(1) || est_d == PW'(NPH - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q   <= '0;
      phase_q <= PW'(HALF);
      stab_q  <= '0;
      lock_q  <= 1'b0;
    end else if (upd) begin
      est_q <= winner_i;
      case (step)
        STEP_UP: phase_q <= phase_q + 1'b1;
        STEP_DN: phase_q <= phase_q - 1'b1;
        default: phase_q <= phase_q;
      endcase
      if (far) begin
        lock_q <= 1'b0;
        stab_q <= '0;
      end else if (step != STEP_HOLD) begin
        stab_q <= '0;
      end else begin
        if (stab_q < SW'(LOCK_WINS)) stab_q <= stab_q + 1'b1;
        if (stab_q >= SW'(LOCK_WINS - 1)) lock_q <= 1'b1;
      end
    end
  end

  assign est_o   = est_q;
  assign phase_o = phase_q;
  assign lock_o  = lock_q;

  p_one_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q == $past(phase_q)) || (phase_q == $past(phase_q) + PW'(1))
             || (phase_q == $past(phase_q) - PW'(1)));

  p_move_at_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(phase_q) && $stable(est_q));

  p_quiet_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && votes_i < VW'(MIN_VOTES)) |=>
      $stable(phase_q) && $stable(est_q) && $stable(lock_q));

  p_lock_at_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(win_end_i));
endmodule

// File: rtl/dcdr_core.sv
module dcdr_core #(
  parameter int NPH       = 8,
  parameter int WIN_LEN   = 16,
  parameter int MIN_VOTES = 2,
  parameter int LOCK_WINS = 4,
  localparam int PW = $clog2(NPH),
  localparam int VW = $clog2(NPH * WIN_LEN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] samp_i,
  output logic           data_o,
  output logic           valid_o,
  output logic [PW-1:0]  phase_o,
  output logic           lock_o
);
  logic [NPH-1:0] edges;
  logic [PW-1:0]  est, winner, phase;
  logic [VW-1:0]  votes;
  logic           win_end, data_q, valid_q;

  dcdr_edge_finder #(.NPH(NPH)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .samp_i  (samp_i),
    .edges_o (edges)
  );

  dcdr_vote_window #(.NPH(NPH), .WIN_LEN(WIN_LEN)) u_vote (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edges_i   (edges),
    .cur_est_i (est),
    .win_end_o (win_end),
    .winner_o  (winner),
    .votes_o   (votes)
  );

  dcdr_phase_ctrl #(
    .NPH(NPH), .WIN_LEN(WIN_LEN), .MIN_VOTES(MIN_VOTES), .LOCK_WINS(LOCK_WINS)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_i (win_end),
    .winner_i  (winner),
    .votes_i   (votes),
    .est_o     (est),
    .phase_o   (phase),
    .lock_o    (lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= samp_i[phase];
      valid_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign phase_o = phase;

  p_valid_after_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_q);

  p_data_from_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> data_q == $past(samp_i[phase]));
endmodule

// File: tb/dcdr_core_bench.sv
module dcdr_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] samp_i = '0;
  logic       data_o, valid_o, lock_o;
  logic [2:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic prev_bit = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dcdr_core u_dcdr_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .samp_i  (samp_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .phase_o (phase_o),
    .lock_o  (lock_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period(input logic [7:0] vec);
    samp_i = vec;
    @(posedge clk_i);
    #1;
  endtask

  // one period with new level b, edge at position e (e = 0 to 7)
  task automatic bit_period(input logic b, input int e);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = (k < e) ? prev_bit : b;
    prev_bit = b;
    period(v);
  endtask

  task automatic edge_window(input int e);
    for (int i = 0; i < WIN; i++) bit_period(~prev_bit, e);
  endtask

  task automatic t_reset_state();
    check("R9 phase in reset", phase_o, 4);
    check("R9 lock in reset", lock_o, 0);
    check("R9 valid in reset", valid_o, 0);
    check("R9 data in reset", data_o, 0);
  endtask

  task automatic t_settle_lock();
    for (int w = 1; w <= 4; w++) begin
      edge_window(0);
      check("R3 phase with edge 0", phase_o, 4);
      check("R6 lock count", lock_o, (w == 4) ? 1 : 0);
    end
    check("R8 valid", valid_o, 1);
    check("R8 data follows sample", data_o, prev_bit);
  endtask

  task automatic t_far_move();
    edge_window(2);
    check("R7 far estimate clears lock", lock_o, 0);
    check("R4 first step", phase_o, 5);
    edge_window(2);
    check("R4 second step", phase_o, 6);
    for (int w = 3; w <= 6; w++) begin
      edge_window(2);
      check("R4 hold at target", phase_o, 6);
      check("R6 relock count", lock_o, (w == 6) ? 1 : 0);
    end
  endtask

  task automatic t_near_move();
    edge_window(3);
    check("R6 one step keeps lock", lock_o, 1);
    check("R3 target 7", phase_o, 7);
  endtask

  task automatic t_quiet();
    for (int i = 0; i < WIN; i++) bit_period(prev_bit, 0);
    check("R5 empty window phase", phase_o, 7);
    check("R5 empty window lock", lock_o, 1);
    bit_period(~prev_bit, 6);
    for (int i = 1; i < WIN; i++) bit_period(prev_bit, 0);
    check("R5 single vote phase", phase_o, 7);
    check("R5 single vote lock", lock_o, 1);
  endtask

  task automatic t_tie();
    for (int i = 0; i < WIN / 2; i++) bit_period(~prev_bit, 3);
    for (int i = 0; i < WIN / 2; i++) bit_period(~prev_bit, 5);
    check("R2 tie keeps estimate phase", phase_o, 7);
    check("R2 tie keeps estimate lock", lock_o, 1);
  endtask

  task automatic t_wrap_and_down();
    edge_window(7);
    check("R7 opposite estimate unlocks", lock_o, 0);
    check("R4 opposite step wraps up", phase_o, 0);
    edge_window(7);
    check("R4 step 0 to 1", phase_o, 1);
    edge_window(7);
    edge_window(7);
    check("R3 target 3", phase_o, 3);
    edge_window(6);
    check("R4 downward step", phase_o, 2);
    check("R1 edge 6 counted", lock_o, 0);
  endtask

  task automatic t_data_select();
    period(8'b0000_0100);
    check("R8 picks phase 2 high", data_o, 1);
    period(8'b1111_1011);
    check("R8 picks phase 2 low", data_o, 0);
  endtask

  task automatic t_reset_again();
    rst_ni = 1'b0;
    #2;
    check("R9 phase after reset", phase_o, 4);
    check("R9 lock after reset", lock_o, 0);
    check("R9 valid after reset", valid_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_settle_lock();
    t_far_move();
    t_near_move();
    t_quiet();
    t_tie();
    t_wrap_and_down();
    t_data_select();
    t_reset_again();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule